// File: doc/BRIEF.md
# Two-Wire Byte-Memory Slave Engine

This block is the bus-facing front end of a byte-addressed memory that answers on a two-wire serial bus. It samples the raw clock and data lines through synchronisers running on a much faster system clock. It finds START and STOP conditions and reads the slave address byte. It acknowledges by pulling the data line low through an open-drain enable. After a write-type selection it collects a two-byte word address, high byte first. It then turns each further byte into a one-cycle write strobe on a parallel memory port.

After a read-type selection the engine fetches a byte with a one-cycle request. It shifts the byte out MSB first. It continues for as long as the master acknowledges. A master that wants a random read sends the word address in a dummy write, then a repeated START with the read bit set. When the master withholds the acknowledge, the engine goes silent until the next STOP or START.

Top module: `twi_mem_slave`

## Requirements
- R1: Out of reset, and until a START has been seen, the engine never drives the data line and never strobes the memory port, whatever the bus clock and data lines do.
- R2: A START (data falls while clock is high) starts reception of an address byte from any state. A repeated START in the middle of a transaction keeps the word address, so a dummy write followed by a read returns data from the written address.
- R3: A STOP (data rises while clock is high) returns the engine to idle from any phase. Bytes clocked after it without a new START are not acknowledged.
- R4: An address byte is accepted only when its seven upper bits, sent MSB first, equal binary 1010 followed by strap[2], strap[1], strap[0]. The engine acknowledges an accepted byte by driving data low during the ninth clock. A rejected byte gets no acknowledge, and neither do any later bytes, until the next START.
- R5: Bit 0 of the address byte selects the direction: 1 is read, 0 is write.
- R6: In a write, the next two bytes form the word address, high byte first. The word address is their concatenation truncated to ADDR_W bits. Both bytes are acknowledged.
- R7: Each later write byte is acknowledged and presented as a single-cycle memWrEn, with memWrData and memAddr held at the current word address. The address then increments, wrapping from 2^ADDR_W-1 to 0.
- R8: A read issues a single-cycle memRdReq at memAddr, and the memory returns memRdData one clock later. The byte goes out MSB first. The engine changes its data drive only while the synchronised bus clock is low, and releases the line for the ninth clock.
- R9: Every read byte increments the word address, wrapping to 0. When the master acknowledges with a low, the next byte comes from the incremented address.
- R10: When the master does not acknowledge a read byte, the engine drives nothing more until a STOP or START. The incremented address is kept, so a following read without a word address continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line (wired level) |
| strap | input | 3 | Board-selected low address bits |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| memAddr | output | ADDR_W | Current word address for the memory port |
| memRdReq | output | 1 | One-cycle read request |
| memRdData | input | 8 | Read data, valid the cycle after memRdReq |
| memWrEn | output | 1 | One-cycle write strobe |
| memWrData | output | 8 | Write data, valid with memWrEn |

## Verification
The bench tries all 128 values of the upper seven address bits against a fixed strap, together with the byte that follows each one. A loose compare would acknowledge a neighbour's address, and an engine that forgot a mismatch would acknowledge the byte after it. Writes and reads are placed across the top of a small array, with junk bits in the high address byte. This catches an address register that does not wrap, or that lets the unused high bits through. A dummy write followed by a repeated START, a read cut short by a withheld acknowledge, and bytes clocked after a STOP with no START check that the engine restarts, goes silent and stays idle as required. A design that got any of these wrong would return data from the wrong location or drive the line when it should be released.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    P_IDLE, P_DEV, P_AHI, P_ALO, P_WR, P_RD, P_WAIT
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic relDrive;
    logic ackDrive;
    logic dataDrive;
    logic capHi;
    logic capLo;
    logic wrStrobe;
    logic fetch;
    logic incAddr;
  } ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteFull;
    logic devMatch;
    logic rwBit;
    logic sdaNow;
  } stat_t;

endpackage

// File: rtl/twi_mem_dp.sv
module twi_mem_dp
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  input  ctl_t              ctl,
  output stat_t             stat,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdReq,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(8);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] rxShift, txShift, hiReg;
  logic [ADDR_W-1:0] addrReg;
  logic rdReqQ;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // synchronisers and one-cycle history; idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign stat.sclRise   = sclS & ~sclQ;
  assign stat.sclFall   = ~sclS & sclQ;
  assign stat.startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stat.stopSeen  = sclS & sclQ & ~sdaQ & sdaS;
  assign stat.byteFull  = (bitCnt == CNT_FULL);
  assign stat.devMatch  = (rxShift[7:1] == {DEV_PREFIX, strap});
  assign stat.rwBit     = rxShift[0];
  assign stat.sdaNow    = sdaS;

  // bit counter and receive shifter: 8 data clocks then the ack clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (stat.startSeen) begin
      bitCnt <= '0;
    end else if (stat.sclRise) begin
      if (stat.byteFull) begin
        bitCnt <= '0;
      end else begin
        bitCnt  <= bitCnt + CNT_W'(1);
        rxShift <= {rxShift[6:0], sdaS};
      end
    end
  end

  // word address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      addrReg <= '0;
    end else begin
      if (ctl.capHi) hiReg <= rxShift;
      if (ctl.capLo) addrReg <= ADDR_W'({hiReg, rxShift});
      else if (ctl.incAddr || memWrEn) addrReg <= addrReg + 1'b1;
    end
  end

  assign memAddr = addrReg;

  // memory port strobes and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memWrData <= '0;
      memRdReq  <= 1'b0;
      rdReqQ    <= 1'b0;
      txShift   <= '0;
    end else begin
      memWrEn  <= ctl.wrStrobe;
      memRdReq <= ctl.fetch;
      rdReqQ   <= memRdReq;
      if (ctl.wrStrobe) memWrData <= rxShift;
      if (rdReqQ) txShift <= memRdData;
      else if (ctl.dataDrive) txShift <= {txShift[6:0], 1'b0};
    end
  end

  // open-drain data drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaDriveLow <= 1'b0;
    else if (ctl.relDrive) sdaDriveLow <= 1'b0;
    else if (ctl.ackDrive) sdaDriveLow <= 1'b1;
    else if (ctl.dataDrive) sdaDriveLow <= ~txShift[7];
  end

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R7
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> memAddr == $past(memAddr) + 1'b1);

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  // R8
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclS);

endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  stat_t stat,
  output ctl_t  ctl
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= P_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    if (stat.startSeen) begin
      phaseNext    = P_DEV;
      ctl.relDrive = 1'b1;
    end else if (stat.stopSeen) begin
      phaseNext    = P_IDLE;
      ctl.relDrive = 1'b1;
    end else if (stat.sclRise && stat.byteFull) begin
      // ninth clock rising: the byte and its acknowledge are complete
      unique case (phase)
        P_DEV: begin
          if (!stat.devMatch) phaseNext = P_WAIT;
          else if (stat.rwBit) begin
            phaseNext = P_RD;
            ctl.fetch = 1'b1;
          end else phaseNext = P_AHI;
        end
        P_AHI: begin
          ctl.capHi = 1'b1;
          phaseNext = P_ALO;
        end
        P_ALO: begin
          ctl.capLo = 1'b1;
          phaseNext = P_WR;
        end
        P_WR: ctl.wrStrobe = 1'b1;
        P_RD: begin
          ctl.incAddr = 1'b1;
          if (!stat.sdaNow) ctl.fetch = 1'b1;
          else phaseNext = P_WAIT;
        end
        default: ;
      endcase
    end else if (stat.sclFall) begin
      unique case (phase)
        P_DEV: begin
          if (stat.byteFull && stat.devMatch) ctl.ackDrive = 1'b1;
          else ctl.relDrive = 1'b1;
        end
        P_AHI, P_ALO, P_WR: begin
          if (stat.byteFull) ctl.ackDrive = 1'b1;
          else ctl.relDrive = 1'b1;
        end
        P_RD: begin
          if (!stat.byteFull) ctl.dataDrive = 1'b1;
          else ctl.relDrive = 1'b1;
        end
        default: ctl.relDrive = 1'b1;
      endcase
    end
  end

  // R2
  start_to_dev_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.startSeen |=> phase == P_DEV);

  // R3
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.stopSeen |=> phase == P_IDLE);

  // R10
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_WAIT && !stat.startSeen && !stat.stopSeen) |=> phase == P_WAIT);

  // R1
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_IDLE) |-> !(ctl.wrStrobe || ctl.fetch || ctl.ackDrive || ctl.dataDrive));

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdReq,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData
);

  ctl_t  ctl;
  stat_t stat;

  twi_mem_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .ctl(ctl), .stat(stat), .sdaDriveLow(sdaDriveLow), .memAddr(memAddr),
    .memRdReq(memRdReq), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrData(memWrData)
  );

  twi_mem_ctrl ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl)
  );

endmodule

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;

  localparam int AW = 10;
  localparam int Q  = 6;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaBus, sdaDriveLow, memRdReq, memWrEn;
  logic [AW-1:0] memAddr;
  logic [7:0] memRdData, memWrData;
  logic [7:0] mem [0:(1<<AW)-1];
  int checks = 0, failures = 0, wrCount = 0, driveSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;

  twi_mem_slave #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .strap(strap),
    .sdaDriveLow(sdaDriveLow), .memAddr(memAddr), .memRdReq(memRdReq),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData)
  );

  // memory model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdReq) memRdData <= mem[memAddr];
    if (rstN && memWrEn) wrCount <= wrCount + 1;
    if (rstN && sdaDriveLow) driveSeen <= driveSeen + 1;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    if (scl == 1'b0) begin
      sdaM = 1'b1; waitc(Q);
      scl = 1'b1;  waitc(Q);
    end
    sdaM = 1'b0; waitc(Q);
    scl = 1'b0;  waitc(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitc(Q);
    scl = 1'b1;  waitc(Q);
    sdaM = 1'b1; waitc(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitc(Q);
      scl = 1'b1;  waitc(2 * Q);
      scl = 1'b0;  waitc(Q);
    end
    sdaM = 1'b1; waitc(Q);
    scl = 1'b1;  waitc(Q);
    ack = ~sdaBus;
    waitc(Q);
    scl = 1'b0;  waitc(Q);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitc(Q);
      scl = 1'b1;  waitc(Q);
      d = {d[6:0], sdaBus};
      waitc(Q);
      scl = 1'b0;  waitc(Q);
    end
    sdaM = ackIt ? 1'b0 : 1'b1; waitc(Q);
    scl = 1'b1; waitc(2 * Q);
    scl = 1'b0; waitc(Q);
    sdaM = 1'b1;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int snap;
    for (int a = 0; a < (1 << AW); a++) mem[a] = pat(a);
    waitc(5);
    rstN = 1'b1;
    waitc(3);
    chk("R1 reset sdaDriveLow", sdaDriveLow, 0);
    chk("R1 reset memWrEn", memWrEn, 0);
    chk("R1 reset memRdReq", memRdReq, 0);

    // R1: bytes with no START are ignored
    scl = 1'b0; waitc(Q);
    writeByte(8'hAA, ack); chk("R1 no ack without START", ack, 0);
    writeByte(8'h00, ack); writeByte(8'h10, ack); writeByte(8'h55, ack);
    chk("R1 no ack on data", ack, 0);
    chk("R1 no write strobes", wrCount, 0);
    chk("R1 no drive", driveSeen, 0);

    // R4: sweep of upper seven address bits, strap = 101 -> match 7'h55
    for (int v = 0; v < 128; v++) begin
      busStart();
      writeByte({7'(v), 1'b0}, ack);
      chk("R4 address ack", ack, (v == 7'h55) ? 1 : 0);
      writeByte(8'h00, ack);
      chk("R4 follow-on byte ack", ack, (v == 7'h55) ? 1 : 0);
      busStop();
    end
    chk("R4 no write strobes in sweep", wrCount, 0);

    // R5: read bit selects read; address still 0
    busStart();
    writeByte(8'hAB, ack); chk("R5 read select ack", ack, 1);
    readByte(1'b0, d); chk("R5 read data at 0", d, pat(0));
    busStop();

    // R6/R7: write across the top with junk high bits (0xFFFE -> 0x3FE)
    busStart();
    writeByte(8'hAA, ack); chk("R6 dev ack", ack, 1);
    writeByte(8'hFF, ack); chk("R6 high byte ack", ack, 1);
    writeByte(8'hFE, ack); chk("R6 low byte ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      writeByte(8'(8'hC0 + k), ack); chk("R7 data ack", ack, 1);
    end
    busStop(); waitc(4);
    chk("R7 mem 3FE", mem[10'h3FE], 8'hC0);
    chk("R7 mem 3FF", mem[10'h3FF], 8'hC1);
    chk("R7 wrap mem 000", mem[10'h000], 8'hC2);
    chk("R7 wrap mem 001", mem[10'h001], 8'hC3);
    chk("R7 mem 002 untouched", mem[10'h002], pat(2));
    chk("R7 write count", wrCount, 4);

    // R2/R8/R9: random read at 0x123 via dummy write + repeated START
    busStart();
    writeByte(8'hAA, ack); writeByte(8'h01, ack); writeByte(8'h23, ack);
    busStart();
    writeByte(8'hAB, ack); chk("R2 repeated START ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      readByte(k < 3, d);
      chk("R8 R9 sequential read", d, pat(16'h123 + k));
    end

    // R10: after the withheld ack the engine stays silent
    snap = driveSeen;
    readByte(1'b0, d);
    chk("R10 silent data", d, 8'hFF);
    chk("R10 no drive after nack", driveSeen, snap);
    busStop();
    busStart();
    writeByte(8'hAB, ack);
    readByte(1'b0, d); chk("R10 current address continues", d, pat(16'h127));
    busStop();

    // R9: read wraps from 3FF to 000
    busStart();
    writeByte(8'hAA, ack); writeByte(8'h03, ack); writeByte(8'hFF, ack);
    busStart();
    writeByte(8'hAB, ack);
    readByte(1'b1, d); chk("R9 read at 3FF", d, 8'hC1);
    readByte(1'b0, d); chk("R9 read wraps to 000", d, 8'hC2);
    busStop();

    // R3: STOP mid-write returns to idle; later bytes without START ignored
    busStart();
    writeByte(8'hAA, ack); writeByte(8'h00, ack);
    busStop();
    scl = 1'b0; waitc(Q);
    writeByte(8'hAA, ack); chk("R3 idle after STOP", ack, 0);
    writeByte(8'h00, ack); chk("R3 idle data byte", ack, 0);

    // R2: repeated START after a write byte keeps the incremented address
    busStart();
    writeByte(8'hAA, ack); writeByte(8'h00, ack); writeByte(8'h40, ack);
    writeByte(8'h5A, ack); chk("R7 write ack at 040", ack, 1);
    busStart();
    writeByte(8'hAB, ack);
    readByte(1'b0, d); chk("R2 read after write restart", d, pat(16'h41));
    busStop(); waitc(4);
    chk("R7 mem 040", mem[10'h040], 8'h5A);
    chk("R7 total writes", wrCount, 5);

    finishRun();
  end

endmodule